// File: doc/BRIEF.md
# Serial Transmitter with Pad-Driver Control

This block is the transmit half of an asynchronous serial port. It takes characters over a valid/ready input and shifts each one out as a frame of one start bit, the data bits least significant first, and one stop bit. The bit rate is set by a one-cycle baud tick from outside the block. It also drives the two signals of a tristate pad: the level to drive and an output-enable.

Software controls the block through four level inputs: transmit enable, polarity invert, single-wire mode and transmit direction.

- **Stopping.** Clearing the enable does not cut a character short. The enable read-back stays high until the stop bit of the character in flight has gone out.
- **Pad behaviour after stopping.** In two-wire mode the pad stays driven at the idle level. In single-wire half-duplex mode the pad is released to high impedance. The pad is also released when the direction input selects receive.
- **Inversion.** Setting the invert control flips every bit on the line, including the idle level.

Top module: `serial_tx_pad`

## Requirements
- R1: The frame is a start bit (logical 0), DATA_W data bits with bit 0 first, then a stop bit (logical 1). `pad_out` shows the start bit from the clock edge that accepts the character. Each clock edge with `baud_tick` high while the shifter is busy advances to the next bit. The edge that takes the tenth tick returns the line to idle. Bits hold between ticks.
- R2: `pad_out` equals the logical line level XOR the `cfg_invert` value of the previous cycle. The idle level is therefore high with invert at 0 and low with invert at 1, both while disabled and between characters.
- R3: `in_ready` is high only while `enable_status` is 1, `cfg_enable` is 1 and no character is in flight. A character is taken on a clock edge with `in_valid` and `in_ready` both high.
- R4: `enable_status` rises on the first clock edge at which `cfg_enable` is sampled high.
- R5: If `cfg_enable` is cleared while a character is in flight, `enable_status` stays 1 until the edge that takes the tick ending the stop bit. It falls on that same edge.
- R6: If `cfg_enable` is cleared while no character is in flight, `enable_status` falls on the next clock edge.
- R7: With `cfg_single_wire` at 0, `pad_oe` is 1. A disabled transmitter holds `pad_out` at the idle level.
- R8: With `cfg_single_wire` at 1, `pad_oe` is 0 whenever `enable_status` is 0. `pad_oe` stays 1 while a character drains after the enable is cleared.
- R9: With `cfg_single_wire` at 1 and `cfg_dir_tx` at 0 (receive), `pad_oe` is 0 from the next edge, even while enabled.
- R10: Setting `cfg_enable` again before a pending shutdown completes cancels it. The frame continues unchanged and `enable_status` stays 1.
- R11: While `rst` is high, `enable_status` and `in_ready` are 0. `pad_out` is 1 regardless of invert, and `pad_oe` is the inverse of `cfg_single_wire`. Both pad outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Transmit enable request |
| cfg_invert | input | 1 | Invert line polarity |
| cfg_single_wire | input | 1 | Single-wire half-duplex mode |
| cfg_dir_tx | input | 1 | Single-wire direction: 1 transmit, 0 receive |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character to send |
| in_ready | output | 1 | Character can be taken |
| baud_tick | input | 1 | One-cycle bit-period strobe |
| enable_status | output | 1 | Effective enable read-back |
| pad_out | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad output-enable |

## Verification
Every pad result is registered at the same edge that samples its cause: an accept, a tick, a change of invert, mode or direction, or the end of a frame. The bench therefore drives inputs at a falling edge, lets one rising edge pass, and checks at the next falling edge. `enable_status` follows the same one-edge rule, both when it rises and when a drain or an idle disable ends. `in_ready` is combinational, so its fall after the enable is cleared is checked a moment after the input changes, before any edge. Each bit is checked again one cycle after its tick to show that it holds between ticks.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic enable;
        logic invert;
        logic single_wire;
        logic dir_tx;
    } tx_ctl_t;

    // Logical line state of the next cycle, produced by the shifter
    typedef struct packed {
        logic busy;
        logic level;
    } line_nx_t;

    function automatic logic pad_level(input logic level, input logic invert);
        return level ^ invert;
    endfunction

    function automatic logic drive_pad(input tx_ctl_t ctl, input logic en_nx);
        return !ctl.single_wire || (en_nx && ctl.dir_tx);
    endfunction

endpackage

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int unsigned DATA_W = stx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              baud_tick,
    output logic              busy,
    output stx_pkg::line_nx_t line_nx
);
    import stx_pkg::*;

    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    sh_state_e          state_q, state_nx;
    logic [FRAME_W-1:0] sh_q, sh_nx;
    logic [CNT_W-1:0]   cnt_q, cnt_nx;

    always_comb begin
        state_nx = state_q;
        sh_nx    = sh_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            SH_IDLE: begin
                if (load) begin
                    state_nx = SH_BUSY;
                    sh_nx    = {1'b1, load_data, 1'b0};
                    cnt_nx   = '0;
                end
            end
            SH_BUSY: begin
                if (baud_tick) begin
                    sh_nx = {1'b1, sh_q[FRAME_W-1:1]};
                    if (cnt_q == LAST) begin
                        state_nx = SH_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            sh_q    <= '1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            sh_q    <= sh_nx;
            cnt_q   <= cnt_nx;
        end
    end

    assign busy          = (state_q == SH_BUSY);
    assign line_nx.busy  = (state_nx == SH_BUSY);
    assign line_nx.level = line_nx.busy ? sh_nx[0] : 1'b1;

endmodule

// File: rtl/stx_enable_ctl.sv
module stx_enable_ctl (
    input  logic clk,
    input  logic rst,
    input  logic req_enable,
    input  logic busy,
    input  logic busy_nx,
    output logic en_q,
    output logic en_nx,
    output logic ready
);
    // Enable holds while a character is still going out after the request drops
    assign en_nx = req_enable || (en_q && busy_nx);

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_nx;
    end

    assign ready = en_q && req_enable && !busy;

endmodule

// File: rtl/stx_pad_drv.sv
module stx_pad_drv (
    input  logic              clk,
    input  logic              rst,
    input  stx_pkg::tx_ctl_t  ctl,
    input  logic              en_nx,
    input  stx_pkg::line_nx_t line_nx,
    output logic              pad_out,
    output logic              pad_oe
);
    import stx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_out <= 1'b1;
            pad_oe  <= !ctl.single_wire;
        end else begin
            pad_out <= pad_level(line_nx.level, ctl.invert);
            pad_oe  <= drive_pad(ctl, en_nx);
        end
    end

endmodule

// File: rtl/serial_tx_pad.sv
module serial_tx_pad #(
    parameter int unsigned DATA_W = stx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_invert,
    input  logic              cfg_single_wire,
    input  logic              cfg_dir_tx,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              baud_tick,
    output logic              enable_status,
    output logic              pad_out,
    output logic              pad_oe
);
    import stx_pkg::*;

    tx_ctl_t  ctl;
    line_nx_t line_nx;
    logic     busy;
    logic     en_nx;
    logic     load;

    assign ctl.enable      = cfg_enable;
    assign ctl.invert      = cfg_invert;
    assign ctl.single_wire = cfg_single_wire;
    assign ctl.dir_tx      = cfg_dir_tx;
    assign load            = in_valid && in_ready;

    stx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (in_data),
        .baud_tick (baud_tick),
        .busy      (busy),
        .line_nx   (line_nx)
    );

    stx_enable_ctl u_en (
        .clk        (clk),
        .rst        (rst),
        .req_enable (ctl.enable),
        .busy       (busy),
        .busy_nx    (line_nx.busy),
        .en_q       (enable_status),
        .en_nx      (en_nx),
        .ready      (in_ready)
    );

    stx_pad_drv u_pad (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .en_nx   (en_nx),
        .line_nx (line_nx),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst,
    input logic cfg_enable,
    input logic cfg_invert,
    input logic cfg_single_wire,
    input logic cfg_dir_tx,
    input logic in_ready,
    input logic enable_status,
    input logic pad_out,
    input logic pad_oe
);
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (enable_status && cfg_enable)); // R3

    AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_enable) && !$past(rst)) |-> enable_status); // R4

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!enable_status && !$past(rst)) |-> (pad_out == !$past(cfg_invert))); // R2

    AST_OE_NORMAL: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_single_wire) |-> pad_oe); // R7

    AST_OE_SW_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_single_wire) && !enable_status) |-> !pad_oe); // R8

    AST_OE_RX_DIR: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_single_wire) && !$past(cfg_dir_tx)) |-> !pad_oe); // R9

endmodule

bind serial_tx_pad stx_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_enable      (cfg_enable),
    .cfg_invert      (cfg_invert),
    .cfg_single_wire (cfg_single_wire),
    .cfg_dir_tx      (cfg_dir_tx),
    .in_ready        (in_ready),
    .enable_status   (enable_status),
    .pad_out         (pad_out),
    .pad_oe          (pad_oe)
);

// File: tb/sim_serial_tx_pad.sv
`timescale 1ns/1ps
module sim_serial_tx_pad;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0, cfg_invert = 1'b0, cfg_single_wire = 1'b0, cfg_dir_tx = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       baud_tick = 1'b0;
    logic       in_ready, enable_status, pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    serial_tx_pad #(.DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_invert(cfg_invert),
        .cfg_single_wire(cfg_single_wire), .cfg_dir_tx(cfg_dir_tx),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .baud_tick(baud_tick), .enable_status(enable_status),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Sends one character and checks every bit; optionally drops/raises enable before tick index
    task automatic send_frame(input logic [7:0] d, input bit inv, input int drop_at,
                              input int reen_at, input bit sw);
        logic exp_bit;
        logic held;
        bit   off;
        off = 1'b0;
        chk(in_ready == 1'b1, "R3 ready before accept", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = d;
        step();
        in_valid = 1'b0;
        chk(pad_out == inv, "R1 start bit", int'(pad_out), int'(inv));
        chk(in_ready == 1'b0, "R3 ready low while busy", int'(in_ready), 0);
        for (int j = 1; j <= 10; j++) begin
            if (j - 1 == drop_at) begin cfg_enable = 1'b0; off = 1'b1; end
            if (j - 1 == reen_at) begin cfg_enable = 1'b1; off = 1'b0; end
            baud_tick = 1'b1;
            step();
            baud_tick = 1'b0;
            exp_bit = (j <= 8) ? d[j-1] : 1'b1;
            chk(pad_out == (exp_bit ^ inv), "R1 R2 frame bit", int'(pad_out), int'(exp_bit ^ inv));
            if (j < 10) begin
                chk(enable_status == 1'b1, "R5 status held during frame", int'(enable_status), 1);
                if (sw) chk(pad_oe == 1'b1, "R8 pad driven while draining", int'(pad_oe), 1);
            end else begin
                chk(enable_status == !off, "R5 R10 status at frame end", int'(enable_status), int'(!off));
                if (sw) chk(pad_oe == !off, "R8 pad released at frame end", int'(pad_oe), int'(!off));
            end
            held = pad_out;
            step();
            chk(pad_out == held, "R1 bit holds between ticks", int'(pad_out), int'(held));
        end
    endtask

    initial begin
        @(negedge clk);
        cfg_invert = 1'b1;
        step();
        step();
        chk(enable_status == 1'b0, "R11 reset status", int'(enable_status), 0);
        chk(in_ready == 1'b0, "R11 reset ready", int'(in_ready), 0);
        chk(pad_out == 1'b1, "R11 reset pad level ignores invert", int'(pad_out), 1);
        chk(pad_oe == 1'b1, "R11 reset oe two-wire", int'(pad_oe), 1);
        cfg_single_wire = 1'b1;
        step();
        chk(pad_oe == 1'b0, "R11 reset oe single-wire", int'(pad_oe), 0);
        cfg_single_wire = 1'b0;
        cfg_invert = 1'b0;
        rst = 1'b0;
        step();
        chk(pad_out == 1'b1 && pad_oe == 1'b1, "R7 disabled drives idle high", int'({pad_out, pad_oe}), 3);
        cfg_invert = 1'b1;
        step();
        chk(pad_out == 1'b0, "R2 R7 disabled idle low when inverted", int'(pad_out), 0);
        chk(pad_oe == 1'b1, "R7 oe stays on while disabled", int'(pad_oe), 1);
        cfg_invert = 1'b0;

        cfg_enable = 1'b1;
        #1;
        chk(enable_status == 1'b0 && in_ready == 1'b0, "R4 status not yet up", int'({enable_status, in_ready}), 0);
        step();
        chk(enable_status == 1'b1, "R4 status rises next edge", int'(enable_status), 1);
        chk(in_ready == 1'b1, "R3 ready when enabled and idle", int'(in_ready), 1);

        cfg_enable = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R3 ready drops with request", int'(in_ready), 0);
        step();
        chk(enable_status == 1'b0, "R6 idle disable next edge", int'(enable_status), 0);
        cfg_enable = 1'b1;
        step();

        for (int inv = 0; inv < 2; inv++) begin
            for (int d = 0; d < 256; d++) begin
                cfg_invert = inv[0];
                step();
                chk(pad_out == !inv[0], "R2 idle between characters", int'(pad_out), int'(!inv[0]));
                send_frame(d[7:0], inv[0], -1, -1, 1'b0);
            end
        end

        cfg_invert = 1'b1;
        step();
        send_frame(8'hA5, 1'b1, 4, -1, 1'b0);
        chk(pad_oe == 1'b1 && pad_out == 1'b0, "R7 disabled two-wire holds inverted idle", int'({pad_out, pad_oe}), 1);
        chk(in_ready == 1'b0, "R3 no ready after shutdown", int'(in_ready), 0);

        cfg_enable = 1'b1;
        cfg_invert = 1'b0;
        step();
        send_frame(8'h3C, 1'b0, 2, 6, 1'b0);
        chk(in_ready == 1'b1, "R10 ready after cancelled shutdown", int'(in_ready), 1);

        cfg_enable = 1'b0;
        cfg_single_wire = 1'b1;
        step();
        chk(pad_oe == 1'b0, "R8 single-wire disabled released", int'(pad_oe), 0);
        cfg_enable = 1'b1;
        step();
        chk(pad_oe == 1'b1 && enable_status == 1'b1, "R8 single-wire enabled drives", int'({enable_status, pad_oe}), 3);
        cfg_dir_tx = 1'b0;
        step();
        chk(pad_oe == 1'b0, "R9 receive direction releases pad", int'(pad_oe), 0);
        chk(enable_status == 1'b1, "R9 enable unaffected by direction", int'(enable_status), 1);
        cfg_dir_tx = 1'b1;
        step();
        chk(pad_oe == 1'b1, "R9 transmit direction drives again", int'(pad_oe), 1);
        send_frame(8'h96, 1'b0, 3, -1, 1'b1);
        chk(pad_oe == 1'b0 && enable_status == 1'b0, "R8 released after drain", int'({enable_status, pad_oe}), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule